// File: doc/BRIEF.md
# Systolic FIR Convolution Array

The block computes a running one-dimensional convolution of a stream of signed samples with a short mask of signed coefficients. It is a linear chain of identical elements, and each element owns one mask coefficient. A sample enters at the left end. At each element it is multiplied by that element's coefficient, and the product is added to a partial sum that comes from the element on the left. The sample and the updated partial sum then move one element to the right. The finished sum leaves the rightmost element. No adder tree is used: once the chain is full, a new result appears on every clock.

The mask is loaded through an indexed write port while the stream is idle. Samples arrive with a qualifier flag. The result carries its own flag, which is set only when every sample in the result's window was flagged valid. The fill of the chain and any gap in the input therefore show up on the output as cycles without a valid result.

Top module: `sconv_chain`

## Requirements
- R1: After reset, every coefficient is zero, `res_valid` is 0 and `res_out` is 0. While the coefficients are still zero, every valid result is 0.
- R2: If `cfg_we` is high at a rising edge and `cfg_idx` equals i (0 ≤ i < TAPS), coefficient i takes the value of `cfg_coef` from that edge onward. All other coefficients keep their values.
- R3: A write with `cfg_idx` ≥ TAPS (indices 5, 6 and 7 at the default TAPS = 5 with a 3-bit index) changes no coefficient.
- R4: Let element 0 be the leftmost element and x(t) the sample presented in cycle t. The result is y(t) = Σ c[i]·x(t−i) for i = 0 … TAPS−1. A lone unit sample therefore produces c[0], c[1], … c[TAPS−1] on consecutive cycles.
- R5: y(t) is on `res_out` after the TAPS-th rising edge, counting the edge that captures x(t) as the first.
- R6: When a valid sample arrives on every cycle, a valid result leaves on every cycle once the chain has filled.
- R7: `res_valid` for y(t) is high exactly when `smp_valid` was high for all of x(t) … x(t−TAPS+1). No valid result appears before 2·TAPS−1 edges after reset. A single invalid input cycle clears TAPS consecutive results.
- R8: Samples and coefficients are 16-bit two's complement. The sum is 32 + ceil(log2 TAPS) bits wide (35 at the default) and never wraps, even with all operands at −32768.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_idx | input | IDX_W | Element number addressed by the write |
| cfg_coef | input | COEF_W | Signed coefficient value to store |
| smp_in | input | SMP_W | Signed input sample |
| smp_valid | input | 1 | Qualifier for `smp_in` |
| res_out | output | ACC_W | Signed convolution result |
| res_valid | output | 1 | Qualifier for `res_out` |

## Verification
A unit impulse, and then a negative impulse, show the output order of the coefficients. These tests tell a true convolution apart from a reversed mask or a sample that meets the same coefficient twice, and they fix the latency to one exact edge. A dense pseudo-random stream checks sustained one-result-per-clock output against an exact reference. Streams with periodic and isolated gaps show whether the valid flag shadows each gap for exactly TAPS results. The tests also include runs before any load (all-zero mask), writes to out-of-range indices, and a rewrite of a single coefficient, which show that only the addressed element changes. Finally, full-scale negative and alternating operands show whether the wide sum wraps.

// File: rtl/conv_pkg.sv
package conv_pkg;

    localparam int unsigned DEF_TAPS   = 5;
    localparam int unsigned DEF_SMP_W  = 16;
    localparam int unsigned DEF_COEF_W = 16;

    // sum width wide enough for taps full-scale products
    function automatic int unsigned acc_width(int unsigned smp_w,
                                              int unsigned coef_w,
                                              int unsigned taps);
        return smp_w + coef_w + ((taps > 1) ? $clog2(taps) : 0);
    endfunction

    function automatic int unsigned idx_width(int unsigned taps);
        return (taps > 1) ? $clog2(taps) : 1;
    endfunction

endpackage

// File: rtl/conv_coef_slot.sv
module conv_coef_slot #(
    parameter int unsigned COEF_W = 16,
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned SLOT   = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic signed [COEF_W-1:0] wr_data,
    output logic signed [COEF_W-1:0] coef
);

    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(SLOT);

    typedef struct packed {
        logic signed [COEF_W-1:0] coef;
    } slot_st;

    slot_st st_d, st_q;
    logic   hit;

    always_comb begin
        hit  = wr_en && (wr_idx == MY_IDX);
        st_d = st_q;
        if (hit) begin
            st_d.coef = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign coef = st_q.coef;

    AST_COEF_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == MY_IDX) |=> (coef == $past(wr_data)))
        else $error("coefficient slot missed its write"); // R2

    AST_COEF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx == MY_IDX) |=> $stable(coef))
        else $error("coefficient slot changed without its index"); // R3

endmodule

// File: rtl/conv_smp_delay.sv
module conv_smp_delay #(
    parameter int unsigned SMP_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [SMP_W-1:0] d,
    input  logic                    d_vld,
    output logic signed [SMP_W-1:0] q,
    output logic                    q_vld
);

    // two stages so each partial sum meets the next older sample
    typedef struct packed {
        logic                    v1;
        logic signed [SMP_W-1:0] s1;
        logic                    v2;
        logic signed [SMP_W-1:0] s2;
    } dly_st;

    dly_st st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.v1 = d_vld;
        st_d.s1 = d;
        st_d.v2 = st_q.v1;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q     = st_q.s2;
    assign q_vld = st_q.v2;

endmodule

// File: rtl/conv_pe.sv
module conv_pe #(
    parameter int unsigned SMP_W  = 16,
    parameter int unsigned COEF_W = 16,
    parameter int unsigned ACC_W  = 35
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [COEF_W-1:0] coef,
    input  logic signed [SMP_W-1:0]  smp,
    input  logic                     smp_vld,
    input  logic signed [ACC_W-1:0]  acc_in,
    input  logic                     acc_vld_in,
    output logic signed [ACC_W-1:0]  acc_out,
    output logic                     acc_vld_out
);

    localparam int unsigned PROD_W = SMP_W + COEF_W;

    typedef struct packed {
        logic                    vld;
        logic signed [ACC_W-1:0] acc;
    } pe_st;

    pe_st                     st_d, st_q;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;

    always_comb begin
        prod     = smp * coef;
        prod_ext = ACC_W'(prod);
        st_d     = st_q;
        st_d.acc = acc_in + prod_ext;
        // the sum stays valid only while every sample it met was valid
        st_d.vld = acc_vld_in & smp_vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_out     = st_q.acc;
    assign acc_vld_out = st_q.vld;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_in[ACC_W-1] == prod_ext[ACC_W-1]) |-> (st_d.acc[ACC_W-1] == acc_in[ACC_W-1]))
        else $error("partial sum wrapped"); // R8

endmodule

// File: rtl/sconv_chain.sv
module sconv_chain
    import conv_pkg::*;
#(
    parameter int unsigned TAPS   = DEF_TAPS,
    parameter int unsigned SMP_W  = DEF_SMP_W,
    parameter int unsigned COEF_W = DEF_COEF_W,
    parameter int unsigned ACC_W  = acc_width(SMP_W, COEF_W, TAPS),
    parameter int unsigned IDX_W  = idx_width(TAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [IDX_W-1:0]         cfg_idx,
    input  logic signed [COEF_W-1:0] cfg_coef,
    input  logic signed [SMP_W-1:0]  smp_in,
    input  logic                     smp_valid,
    output logic signed [ACC_W-1:0]  res_out,
    output logic                     res_valid
);

    localparam int unsigned FILL = 2 * TAPS - 1;
    localparam int unsigned FC_W = $clog2(FILL + 1);

    logic signed [SMP_W-1:0]  smp_c  [TAPS];
    logic                     smpv_c [TAPS];
    logic signed [COEF_W-1:0] coef_c [TAPS];
    logic signed [ACC_W-1:0]  acc_c  [TAPS+1];
    logic                     accv_c [TAPS+1];

    assign smp_c[0]  = smp_in;
    assign smpv_c[0] = smp_valid;
    assign acc_c[0]  = '0;
    assign accv_c[0] = 1'b1;

    for (genvar g = 0; g < TAPS; g++) begin : g_el
        conv_coef_slot #(
            .COEF_W (COEF_W),
            .IDX_W  (IDX_W),
            .SLOT   (g)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_we),
            .wr_idx  (cfg_idx),
            .wr_data (cfg_coef),
            .coef    (coef_c[g])
        );

        conv_pe #(
            .SMP_W  (SMP_W),
            .COEF_W (COEF_W),
            .ACC_W  (ACC_W)
        ) u_pe (
            .clk         (clk),
            .rst_n       (rst_n),
            .coef        (coef_c[g]),
            .smp         (smp_c[g]),
            .smp_vld     (smpv_c[g]),
            .acc_in      (acc_c[g]),
            .acc_vld_in  (accv_c[g]),
            .acc_out     (acc_c[g+1]),
            .acc_vld_out (accv_c[g+1])
        );

        if (g < TAPS - 1) begin : g_fwd
            conv_smp_delay #(
                .SMP_W (SMP_W)
            ) u_dly (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (smp_c[g]),
                .d_vld (smpv_c[g]),
                .q     (smp_c[g+1]),
                .q_vld (smpv_c[g+1])
            );
        end
    end

    assign res_out   = acc_c[TAPS];
    assign res_valid = accv_c[TAPS];

    // edges since reset, saturating, used only by the fill check
    logic [FC_W-1:0] fill_d, fill_q;

    always_comb begin
        fill_d = fill_q;
        if (fill_q != FC_W'(FILL)) begin
            fill_d = fill_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else begin
            fill_q <= fill_d;
        end
    end

    AST_FILL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (fill_q == FC_W'(FILL)))
        else $error("result flagged before the chain could fill"); // R7

endmodule

// File: tb/sim_sconv_chain.sv
`timescale 1ns/1ps
module sim_sconv_chain;

    localparam int TAPS = 5;
    localparam int SW   = 16;
    localparam int CW   = 16;
    localparam int AW   = SW + CW + $clog2(TAPS);
    localparam int IW   = 3;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 cfg_we;
    logic [IW-1:0]        cfg_idx;
    logic signed [CW-1:0] cfg_coef;
    logic signed [SW-1:0] smp_in;
    logic                 smp_valid;
    logic signed [AW-1:0] res_out;
    logic                 res_valid;

    always #4 clk = ~clk;

    sconv_chain #(
        .TAPS   (TAPS),
        .SMP_W  (SW),
        .COEF_W (CW)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_coef  (cfg_coef),
        .smp_in    (smp_in),
        .smp_valid (smp_valid),
        .res_out   (res_out),
        .res_valid (res_valid)
    );

    typedef struct {
        int     due;
        bit     vld;
        longint val;
        int     req;
    } exp_t;

    exp_t   expq[$];
    exp_t   mon_e;
    int     checks = 0;
    int     bad    = 0;
    int     cyc    = 0;
    int     cur_req = 1;
    bit     mon_on = 1'b0;
    bit     done   = 1'b0;
    longint cm [TAPS];
    longint xh [TAPS];
    bit     vh [TAPS];
    logic [15:0] lf = 16'hACE1;

    always @(posedge clk) if (rst_n === 1'b1) cyc <= cyc + 1;

    function automatic logic signed [15:0] next_rand();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return lf;
    endfunction

    // driver: one call per clock, pushes the expected result for this cycle
    task automatic tick(input bit v, input logic signed [15:0] x,
                        input bit we, input logic [IW-1:0] idx,
                        input logic signed [15:0] c);
        exp_t   e;
        longint s;
        bit     ok;
        @(negedge clk);
        smp_valid = v;
        smp_in    = x;
        cfg_we    = we;
        cfg_idx   = idx;
        cfg_coef  = c;
        if (we && int'(idx) < TAPS) cm[idx] = longint'(c);
        for (int i = TAPS - 1; i > 0; i--) begin
            xh[i] = xh[i-1];
            vh[i] = vh[i-1];
        end
        xh[0] = longint'(x);
        vh[0] = v;
        s  = 0;
        ok = 1'b1;
        for (int i = 0; i < TAPS; i++) begin
            s  = s + cm[i] * xh[i];
            ok = ok & vh[i];
        end
        e.due = cyc + TAPS;
        e.vld = ok;
        e.val = s;
        e.req = cur_req;
        expq.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick(1'b0, 16'sd0, 1'b0, '0, 16'sd0);
    endtask

    task automatic feed(input logic signed [15:0] x);
        tick(1'b1, x, 1'b0, '0, 16'sd0);
    endtask

    task automatic load(input int idx, input logic signed [15:0] c);
        tick(1'b0, 16'sd0, 1'b1, IW'(idx), c);
    endtask

    // monitor: compares each result cycle against the queue
    always @(negedge clk) begin
        if (mon_on && !done) begin
            if (expq.size() > 0 && expq[0].due == cyc) begin
                mon_e = expq.pop_front();
                checks++;
                if (res_valid !== mon_e.vld) begin
                    bad++;
                    $display("FAIL R%0d/R7 cyc=%0d res_valid act=%0b exp=%0b",
                             mon_e.req, cyc, res_valid, mon_e.vld);
                end else if (mon_e.vld) begin
                    checks++;
                    if (longint'(res_out) != mon_e.val) begin
                        bad++;
                        $display("FAIL R%0d cyc=%0d res_out act=%0d exp=%0d",
                                 mon_e.req, cyc, longint'(res_out), mon_e.val);
                    end
                end
            end else begin
                checks++;
                if (res_valid !== 1'b0) begin
                    bad++;
                    $display("FAIL R7 cyc=%0d res_valid act=%0b exp=0", cyc, res_valid);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < TAPS; i++) begin
            cm[i] = 0;
            xh[i] = 0;
            vh[i] = 1'b0;
        end
        rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_coef = '0;
        smp_in = '0; smp_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state seen at the ports
        checks++;
        if (res_valid !== 1'b0 || res_out !== '0) begin
            bad++;
            $display("FAIL R1 reset act=%0b/%0d exp=0/0", res_valid, res_out);
        end
        mon_on = 1'b1;

        // R1: all-zero mask gives zero results
        cur_req = 1;
        for (int k = 0; k < 12; k++) feed(next_rand());
        idle(TAPS + 1);

        // R2: load the mask
        cur_req = 2;
        load(0, 16'sd3);
        load(1, -16'sd2);
        load(2, 16'sd7);
        load(3, 16'sd1);
        load(4, -16'sd5);

        // R3: out-of-range indices are ignored
        cur_req = 3;
        load(5, 16'sd12345);
        load(6, -16'sd999);
        load(7, 16'sd32767);
        idle(TAPS + 1);
        for (int k = 0; k < 10; k++) feed(next_rand());
        idle(TAPS + 1);

        // R4, R5: impulses give the mask in order at a fixed latency
        cur_req = 4;
        for (int k = 0; k < TAPS; k++) feed(16'sd0);
        feed(16'sd1);
        for (int k = 0; k < TAPS + 2; k++) feed(16'sd0);
        cur_req = 5;
        feed(-16'sd1);
        for (int k = 0; k < TAPS + 2; k++) feed(16'sd0);

        // R6: dense random stream
        cur_req = 6;
        for (int k = 0; k < 40; k++) feed(next_rand());

        // R7: gaps in the input flag
        cur_req = 7;
        for (int k = 0; k < 42; k++) begin
            if (k % 7 == 3) tick(1'b0, next_rand(), 1'b0, '0, 16'sd0);
            else feed(next_rand());
        end
        tick(1'b0, 16'sd0, 1'b0, '0, 16'sd0);
        for (int k = 0; k < 12; k++) feed(next_rand());
        idle(TAPS + 1);

        // R2: rewrite one coefficient, the rest keep their values
        cur_req = 2;
        load(2, 16'sd100);
        idle(1);
        for (int k = 0; k < 20; k++) feed(next_rand());
        idle(TAPS + 1);

        // R8: full-scale operands
        cur_req = 8;
        for (int i = 0; i < TAPS; i++) load(i, -16'sd32768);
        idle(1);
        for (int k = 0; k < 10; k++) feed(-16'sd32768);
        for (int k = 0; k < 10; k++) feed((k % 2 == 0) ? 16'sd32767 : -16'sd32768);
        for (int i = 0; i < TAPS; i++) load(i, (i % 2 == 0) ? 16'sd32767 : -16'sd32768);
        idle(1);
        for (int k = 0; k < 12; k++) feed((k % 2 == 0) ? 16'sd32767 : -16'sd32768);

        idle(TAPS + 3);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule